// File: doc/BRIEF.md
# Length-Checked LSB-First Serial Register Target

This block is a serial target for a fixed 24-bit word in clock mode 0: the host samples on the rising serial clock and drives on the falling edge. Bits travel least significant first. In one frame the host writes one of two control registers and reads back one of two status words. Bit 0 of the incoming word is the first bit received, and it picks both the register written and the status word returned.

A write takes effect only after the select line returns high, and only if exactly 24 rising clock edges were counted while it was low. A frame with any other length leaves both control registers as they were. While the select line is low and before the first clock, the data output shows a fault summary. The host can therefore poll for faults without running a full frame. Two control bits act on accepted frames: one requests a clear of the external status bits, and one, when written as zero into register 0, sends the block into standby.

The pins are brought into a fast system clock through synchronizer chains, and every serial edge is detected in that domain. The serial clock must therefore run well below the system clock.

Top module: `frame_checked_spi_target`

## Requirements
- R1: The serial input is sampled on the rising serial clock edge, and the first bit received becomes bit 0 of the stored word (LSB first).
- R2: A frame is accepted only if exactly 24 rising serial clock edges occur while the select line is low. Frames of 0, 23, 25 or 40 edges leave both control registers unchanged and produce no pulse. The edge counter saturates, so long frames cannot wrap back to 24.
- R3: In an accepted frame, bit 0 = 0 writes control register 0 (`ctrl0_o`) and bit 0 = 1 writes control register 1 (`ctrl1_o`). The other register is unchanged.
- R4: While the select line is high, `sdo_oe_o` = 0 and `sdo_o` = 0.
- R5: After the select line falls and before the first serial clock, `sdo_oe_o` = 1. At that point `sdo_o` equals the fault summary, which is the OR of bits 22..1 of both `stat0_i` and `stat1_i`. Bit 0 of the status inputs does not contribute.
- R6: The first rising serial edge of a frame loads the status word chosen by the bit sampled on that edge (0 → `stat0_i`, 1 → `stat1_i`), with its bit 0 replaced by the fault summary. Each later falling edge presents the next bit, LSB first. After 24 falling edges `sdo_o` is 0.
- R7: An accepted frame with bit 22 = 1 (to either register) gives exactly one single-cycle pulse on `clr_stat_o`.
- R8: An accepted frame to register 0 with bit 23 = 0 gives one single-cycle pulse on `standby_o` and clears both control registers to zero. A register 1 write with bit 23 = 0 does not enter standby.
- R9: After reset, both control registers are zero, both pulses are low and `sdo_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| stat0_i | input | WORD_W | Status word 0 |
| stat1_i | input | WORD_W | Status word 1 |
| ctrl0_o | output | WORD_W | Control register 0 |
| ctrl1_o | output | WORD_W | Control register 1 |
| clr_stat_o | output | 1 | Status clear request pulse |
| standby_o | output | 1 | Standby entry pulse |

## Verification
The embedded assertions check, on every cycle, several invariants:
- a control register changes only after an accepted-frame strobe;
- the edge counter stays within its saturation bound;
- the output shifter's loaded state does not outlive the frame;
- the clear and standby pulses last one cycle, and standby coincides with zeroed registers.

Whether the right bits reach the right register, and whether the read-back stream follows the LSB-first order, can only be shown by the bench's frames. The same holds for rejection of short, long and empty frames and for the fault summary before the first clock. The bench compares these against a behavioural model.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int unsigned WORD_W  = 24;
  localparam int unsigned SEL_POS = 0;
  localparam int unsigned FLT_LO  = 1;
  localparam int unsigned FLT_HI  = 22;
  localparam int unsigned CLR_POS = 22;
  localparam int unsigned RUN_POS = 23;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned N       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= {(STAGES+1){RST_VAL[g]}};
      else         sh_q <= {sh_q[STAGES-1:0], pin_i[g]};
    end
    assign lvl_o[g]  = sh_q[STAGES-1];
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
  end
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              cs_active_i,
  input  logic              sck_rise_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_valid_o,
  output logic              first_rise_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic              wr_q;
  logic              take;

  assign take = cs_active_i & sck_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= cs_rise_i && (cnt_q == CNT_FULL);
      if (cs_fall_i) cnt_q <= '0;
      else if (take && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (take) sh_q <= {sdi_i, sh_q[WORD_W-1:1]};
    end
  end

  assign word_o       = sh_q;
  assign wr_valid_o   = wr_q;
  assign first_rise_o = take && (cnt_q == '0);

  a_r2_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_SAT);
  a_r2_sat_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_SAT && !cs_fall_i) |=> cnt_q == CNT_SAT);
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              shift_i,
  input  logic              fault_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [WORD_W-1:0] tx_q;
  logic              loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '0;
      loaded_q <= 1'b0;
    end else if (!cs_active_i) begin
      loaded_q <= 1'b0;
    end else if (load_i) begin
      tx_q     <= load_word_i;
      loaded_q <= 1'b1;
    end else if (shift_i && loaded_q) begin
      tx_q <= tx_q >> 1;
    end
  end

  assign sdo_oe_o = cs_active_i;
  assign sdo_o    = !cs_active_i ? 1'b0 : (loaded_q ? tx_q[0] : fault_i);

  a_r6_load_ends_with_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && !cs_active_i) |=> !loaded_q);
endmodule

// File: rtl/frame_checked_spi_target.sv
module frame_checked_spi_target #(
  parameter int unsigned WORD_W      = spi_tgt_pkg::WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [WORD_W-1:0] stat0_i,
  input  logic [WORD_W-1:0] stat1_i,
  output logic [WORD_W-1:0] ctrl0_o,
  output logic [WORD_W-1:0] ctrl1_o,
  output logic              clr_stat_o,
  output logic              standby_o
);
  import spi_tgt_pkg::*;

  localparam int unsigned P_SEL = 0, P_SCK = 1, P_SDI = 2;

  logic [2:0] lvl, rise, fall;
  logic [WORD_W-1:0] rx_word, rd_word, ctrl0_q, ctrl1_q;
  logic wr_valid, first_rise, fault, cs_active, clr_q, stby_q;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i, .rst_ni,
    .pin_i ({sdi_i, sclk_i, sel_n_i}),
    .lvl_o (lvl), .rise_o(rise), .fall_o(fall)
  );

  assign cs_active = ~lvl[P_SEL];

  spi_rx_frame #(.WORD_W(WORD_W)) u_rx (
    .clk_i, .rst_ni,
    .cs_fall_i   (fall[P_SEL]),
    .cs_rise_i   (rise[P_SEL]),
    .cs_active_i (cs_active),
    .sck_rise_i  (rise[P_SCK]),
    .sdi_i       (lvl[P_SDI]),
    .word_o      (rx_word),
    .wr_valid_o  (wr_valid),
    .first_rise_o(first_rise)
  );

  assign fault = (|stat0_i[FLT_HI:FLT_LO]) | (|stat1_i[FLT_HI:FLT_LO]);

  always_comb begin
    rd_word = lvl[P_SDI] ? stat1_i : stat0_i;
    rd_word[0] = fault;
  end

  spi_tx_shift #(.WORD_W(WORD_W)) u_tx (
    .clk_i, .rst_ni,
    .cs_active_i (cs_active),
    .load_i      (first_rise),
    .load_word_i (rd_word),
    .shift_i     (fall[P_SCK]),
    .fault_i     (fault),
    .sdo_o, .sdo_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      clr_q   <= 1'b0;
      stby_q  <= 1'b0;
    end else begin
      clr_q  <= 1'b0;
      stby_q <= 1'b0;
      if (wr_valid) begin
        clr_q <= rx_word[CLR_POS];
        if (rx_word[SEL_POS]) begin
          ctrl1_q <= rx_word;
        end else if (!rx_word[RUN_POS]) begin
          ctrl0_q <= '0;
          ctrl1_q <= '0;
          stby_q  <= 1'b1;
        end else begin
          ctrl0_q <= rx_word;
        end
      end
    end
  end

  assign ctrl0_o    = ctrl0_q;
  assign ctrl1_o    = ctrl1_q;
  assign clr_stat_o = clr_q;
  assign standby_o  = stby_q;

  a_r2_ctrl0_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl0_q != $past(ctrl0_q)) |-> $past(wr_valid));
  a_r2_ctrl1_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl1_q != $past(ctrl1_q)) |-> $past(wr_valid));
  a_r7_clear_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> !clr_q);
  a_r8_standby_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_q |-> (ctrl0_q == '0 && ctrl1_q == '0));
  a_r8_standby_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_q |=> !stby_q);
endmodule

// File: tb/tb_frame_checked_spi_target.sv
`timescale 1ns/1ps
module tb_frame_checked_spi_target;
  localparam int W = 24;
  localparam int H = 5;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe, clr, stby;
  logic [W-1:0] stat0 = '0, stat1 = '0, ctrl0, ctrl1;

  int tests = 0, fails = 0;
  int clr_seen = 0, stby_seen = 0, exp_clr = 0, exp_stby = 0;
  int cyc = 0;
  bit busy = 1, done = 0;
  logic [W-1:0] exp0 = '0, exp1 = '0;

  always #2 clk = ~clk;

  frame_checked_spi_target dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .stat0_i(stat0), .stat1_i(stat1),
    .ctrl0_o(ctrl0), .ctrl1_o(ctrl1), .clr_stat_o(clr), .standby_o(stby)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && clr)  clr_seen++;
    if (rst_n && stby) stby_seen++;
    if (rst_n && !busy && !done) begin
      chk(ctrl0 === exp0, "R3 ctrl0", ctrl0, exp0);
      chk(ctrl1 === exp1, "R3 ctrl1", ctrl1, exp1);
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic frame(input logic [W-1:0] w, input int n, input logic [W-1:0] s0, input logic [W-1:0] s1);
    logic flt;
    logic [W-1:0] rd;
    busy = 1;
    stat0 = s0; stat1 = s1;
    flt = (|s0[22:1]) | (|s1[22:1]);
    rd = w[0] ? s1 : s0;
    rd[0] = flt;
    @(negedge clk);
    sel_n = 0;
    repeat (H) @(negedge clk);
    chk(sdo_oe === 1'b1 && sdo === flt, "R5 fault summary", {22'b0, sdo_oe, sdo}, {22'b0, 1'b1, flt});
    for (int i = 0; i < n; i++) begin
      sdi = (i < W) ? w[i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i < W) chk(sdo === rd[i], $sformatf("R6 read bit %0d", i), {23'b0, sdo}, {23'b0, rd[i]});
      sclk = 1;
      repeat (H) @(negedge clk);
      sclk = 0;
    end
    repeat (H) @(negedge clk);
    if (n == W) chk(sdo === 1'b0, "R6 drained", {23'b0, sdo}, '0);
    sel_n = 1;
    repeat (8) @(negedge clk);
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R4 released", {22'b0, sdo_oe, sdo}, '0);
    if (n == W) begin
      if (w[22]) exp_clr++;
      if (w[0]) exp1 = w;
      else if (!w[23]) begin exp0 = '0; exp1 = '0; exp_stby++; end
      else exp0 = w;
    end
    chk(clr_seen == exp_clr, "R7 clear pulses", W'(clr_seen), W'(exp_clr));
    chk(stby_seen == exp_stby, "R8 standby pulses", W'(stby_seen), W'(exp_stby));
    busy = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ctrl0 === '0 && ctrl1 === '0, "R9 reset ctrl", ctrl0 | ctrl1, '0);
    chk(sdo_oe === 1'b0 && clr === 1'b0 && stby === 1'b0, "R9 reset outputs", {21'b0, sdo_oe, clr, stby}, '0);
    busy = 0;
    // R1 R3: distinct patterns to each register
    frame(24'h80_1234, 24, 24'h00_0100, 24'h00_0000);
    frame(24'hA5_5A5B, 24, 24'h00_0000, 24'h3C_0F0E);
    frame(24'h9E_3C71, 24, 24'h00_0001, 24'h00_0001);
    // R2: wrong lengths rejected
    frame(24'h81_0000, 23, 24'h00_0001, 24'h00_0000);
    frame(24'hC1_FFFF, 25, 24'h40_0000, 24'h00_0000);
    frame(24'hC0_0000, 40, 24'h00_0000, 24'h00_0000);
    frame(24'hC0_0001, 0,  24'h00_0002, 24'h00_0000);
    // R7: clear via register 1
    frame(24'hC0_0001, 24, 24'h00_0000, 24'h7F_FFFE);
    // R8: bit 23 low in register 1 is not standby
    frame(24'h40_0003, 24, 24'h00_0000, 24'h00_0000);
    // R8: standby via register 0 with clear
    frame(24'h40_0FF0, 24, 24'h12_3450, 24'h00_0000);
    frame(24'h8F_FFFE, 24, 24'hFF_FFFF, 24'hAA_AAAA);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule